// File: doc/BRIEF.md
# Channelized Loopback Pattern Search Detector

This block watches a time-division multiplexed serial stream for two in-band pseudo-random code patterns: one that asks the far end to close a loopback and one that asks it to open it again. The host chooses which 8-bit timeslots of the frame take part in the search. Bits in all other timeslots never reach the pattern checkers or the timeout counter. A frame sync input realigns the timeslot counter, and a bit-enable input qualifies each serial bit.

The host starts a search by flipping a restart control. From then on the block shows two live levels. One reports that a loopback is active: it is set by the loop-up pattern and cleared by the loop-down pattern. The other reports a timeout: the loop-up pattern did not show up within a programmable number of searched bits. Any change of these levels sets a sticky flag. The host clears that flag with a write-one strobe, and the flag can raise an interrupt. The block gives status only. Switching the transmit path into loopback is left to the host.

Top module: `lbSearchTop`

## Requirements
- R1: A bit is searched only when `bitEn` is 1 and bit k of `slotEnable` is 1 for its timeslot k. Bits of disabled timeslots change neither the detection nor the timeout count.
- R2: A bit taken with `bitEn` and `frameSync` both 1 is the first (most significant) bit of timeslot 0. Timeslot k covers the 8 bits from 8k to 8k+7 after that bit, across 32 timeslots.
- R3: Any change of level on `hostRestart` clears both status flags, the pattern checkers and the timeout counter at the next clock edge, and starts a new search. A restart does not set `stickyChange`.
- R4: The loop-up pattern follows b[n] = b[n-7] XOR b[n-6]. The first 7 searched bits after a restart only fill the history. After that, searched bits form back-to-back windows of 2048. `loopActive` rises at the edge of the last bit of a window with at most 8 mismatches, which is the 2055th searched bit after a restart when the pattern is clean.
- R5: A window with 9 or more mismatches against the prediction from the received history is not a detection.
- R6: A window that holds no 1 bit is never a detection, even though it has no mismatches.
- R7: The loop-down pattern follows b[n] = b[n-7] XOR b[n-4]. It clears `loopActive` only while that flag is 1. Loop-down has no effect while the flag is 0, and loop-up has no effect while it is 1.
- R8: `timeoutFlag` rises at the edge of the searched bit that brings the count since the restart to `timeoutWin`, or to 65536 when `timeoutWin` is 0, provided no loop-up has been seen. The flag then stays at 1 until the next restart.
- R9: While `loopActive` is 1 the timeout count is held at zero, and `timeoutFlag` cannot rise.
- R10: `stickyChange` is set when either status flag changes for any reason other than a restart, and is cleared by `stickyClr`. `irq` equals `stickyChange` AND `irqEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Serial data bit |
| bitEn | input | 1 | Qualifies `serIn` for this cycle |
| frameSync | input | 1 | Marks the first bit of a frame |
| slotEnable | input | 32 | One search enable per timeslot |
| timeoutWin | input | 20 | Timeout length in searched bits; 0 selects 65536 |
| hostRestart | input | 1 | Search restart; any change of level restarts |
| stickyClr | input | 1 | Write-one strobe that clears `stickyChange` |
| irqEn | input | 1 | Interrupt enable |
| loopActive | output | 1 | Loop-up seen and loop-down not yet seen |
| timeoutFlag | output | 1 | Loop-up not found within the window |
| stickyChange | output | 1 | Sticky record of a status change |
| irq | output | 1 | Interrupt request |

## Verification
Both status flags and the sticky flag are registered once behind the searched bit that causes them. The bench therefore streams an exact number of searched bits and reads the outputs at the falling edge that follows the rising edge of the last one. It reads once after count minus one to see the old value, and once after count to see the new one. A restart and a sticky clear take effect at the rising edge where they are first seen. `irq` is combinational from `irqEn`, so the bench reads it a short delay after changing that enable.

// File: rtl/lbSearchPkg.sv
package lbSearchPkg;

  // Strobes from control to the datapath
  typedef struct packed {
    logic clear;   // restart: wipe checkers and timeout count
    logic toRun;   // timeout counter may advance
  } lbStrobe_t;

  // Single-cycle events from the datapath to control
  typedef struct packed {
    logic upHit;
    logic downHit;
    logic toHit;
  } lbEvent_t;

endpackage

// File: rtl/lbPatChecker.sv
module lbPatChecker #(
  parameter int ORDER = 7,
  parameter int TAP   = 6,
  parameter int WIN   = 2048,
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic bitValid,
  input  logic bitIn,
  output logic hit
);
  localparam int WIN_W  = $clog2(WIN);
  localparam int ERR_W  = $clog2(WIN + 1);
  localparam int FILL_W = $clog2(ORDER + 1);

  logic [ORDER-1:0] hist;
  logic [FILL_W-1:0] fillCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [ERR_W-1:0]  errCnt;
  logic              seenOne;

  logic predBit, misBit, scored, lastBit;
  logic [ERR_W-1:0] errTot;

  always_comb begin
    predBit = hist[ORDER-1] ^ hist[TAP-1];
    misBit  = bitIn ^ predBit;
    scored  = bitValid && (fillCnt == FILL_W'(ORDER));
    lastBit = (winCnt == WIN_W'(WIN - 1));
    errTot  = errCnt + {{(ERR_W-1){1'b0}}, misBit};
    hit     = scored && lastBit && (errTot <= ERR_W'(LIMIT)) && (seenOne || bitIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      hist    <= '0;
      fillCnt <= '0;
      winCnt  <= '0;
      errCnt  <= '0;
      seenOne <= 1'b0;
    end else if (bitValid) begin
      hist <= {hist[ORDER-2:0], bitIn};
      if (!scored) begin
        fillCnt <= fillCnt + FILL_W'(1);
      end else if (lastBit) begin
        winCnt  <= '0;
        errCnt  <= '0;
        seenOne <= 1'b0;
      end else begin
        winCnt  <= winCnt + WIN_W'(1);
        errCnt  <= errTot;
        seenOne <= seenOne | bitIn;
      end
    end
  end

  // R5: mismatches in a window can never outnumber the scored bits
  a_r5_err_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ({{(ERR_W-WIN_W){1'b0}}, winCnt} >= errCnt));

endmodule

// File: rtl/lbDatapath.sv
module lbDatapath
  import lbSearchPkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BITS  = 8,
  parameter int ORDER      = 7,
  parameter int UP_TAP     = 6,
  parameter int DOWN_TAP   = 4,
  parameter int DETECT_LEN = 2048,
  parameter int ERR_LIMIT  = 8,
  parameter int TO_W       = 20,
  parameter int TO_DEFAULT = 65536
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lbStrobe_t            str,
  input  logic                 serIn,
  input  logic                 bitEn,
  input  logic                 frameSync,
  input  logic [NUM_SLOTS-1:0] slotEnable,
  input  logic [TO_W-1:0]      timeoutWin,
  output lbEvent_t             evt
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);

  logic [SLOT_W-1:0] slotCnt, curSlot;
  logic [BIT_W-1:0]  bitCnt, curBit;
  logic              bitValid;
  logic [TO_W-1:0]   toCnt, winEff;
  logic [1:0]        hits;

  always_comb begin
    curSlot  = frameSync ? '0 : slotCnt;
    curBit   = frameSync ? '0 : bitCnt;
    bitValid = bitEn && slotEnable[curSlot];
    winEff   = (timeoutWin == '0) ? TO_W'(TO_DEFAULT) : timeoutWin;
  end

  // Timeslot position: reset by frame sync, advanced per bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      bitCnt  <= '0;
    end else if (bitEn) begin
      if (curBit == BIT_W'(SLOT_BITS - 1)) begin
        bitCnt  <= '0;
        slotCnt <= (curSlot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : curSlot + SLOT_W'(1);
      end else begin
        bitCnt  <= curBit + BIT_W'(1);
        slotCnt <= curSlot;
      end
    end
  end

  // Two checkers, one per pattern, differing only in feedback tap
  for (genvar g = 0; g < 2; g++) begin : gChk
    localparam int TAP = (g == 0) ? UP_TAP : DOWN_TAP;
    lbPatChecker #(
      .ORDER(ORDER), .TAP(TAP), .WIN(DETECT_LEN), .LIMIT(ERR_LIMIT)
    ) u_chk (
      .clk(clk), .rstN(rstN), .clear(str.clear),
      .bitValid(bitValid), .bitIn(serIn), .hit(hits[g])
    );
  end

  // Timeout counter over searched bits
  always_ff @(posedge clk) begin
    if (!rstN || str.clear || !str.toRun) toCnt <= '0;
    else if (bitValid)                    toCnt <= toCnt + TO_W'(1);
  end

  always_comb begin
    evt.upHit   = hits[0];
    evt.downHit = hits[1];
    evt.toHit   = bitValid && str.toRun && (toCnt == winEff - TO_W'(1));
  end

  // R1: no event without a searched bit
  a_r1_event_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    (evt.upHit || evt.downHit) |-> (bitEn && slotEnable[curSlot]));

endmodule

// File: rtl/lbControl.sv
module lbControl
  import lbSearchPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostRestart,
  input  logic      stickyClr,
  input  logic      irqEn,
  input  lbEvent_t  evt,
  output lbStrobe_t str,
  output logic      loopActive,
  output logic      timeoutFlag,
  output logic      stickyChange,
  output logic      irq
);
  logic restartQ, restartTgl;
  logic loopNext, toNext, anyChange;

  always_comb begin
    restartTgl = hostRestart ^ restartQ;
    loopNext   = loopActive;
    toNext     = timeoutFlag;
    if (!loopActive && evt.upHit)     loopNext = 1'b1;
    else if (loopActive && evt.downHit) loopNext = 1'b0;
    if (!timeoutFlag && evt.toHit && !loopNext) toNext = 1'b1;
    anyChange  = !restartTgl && ((loopNext != loopActive) || (toNext != timeoutFlag));
    str.clear  = restartTgl;
    str.toRun  = !loopActive && !timeoutFlag;
    irq        = stickyChange && irqEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restartQ     <= 1'b0;
      loopActive   <= 1'b0;
      timeoutFlag  <= 1'b0;
      stickyChange <= 1'b0;
    end else begin
      restartQ <= hostRestart;
      if (restartTgl) begin
        loopActive  <= 1'b0;
        timeoutFlag <= 1'b0;
      end else begin
        loopActive  <= loopNext;
        timeoutFlag <= toNext;
      end
      if (anyChange)      stickyChange <= 1'b1;
      else if (stickyClr) stickyChange <= 1'b0;
    end
  end

  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hostRestart != restartQ) |=> (!loopActive && !timeoutFlag));

  a_r8_timeout_holds: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && (hostRestart == restartQ)) |=> timeoutFlag);

  a_r9_no_timeout_in_loop: assert property (@(posedge clk) disable iff (!rstN)
    loopActive |=> !$rose(timeoutFlag));

  a_r10_upHit_sets_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((hostRestart == restartQ) && evt.upHit && !loopActive) |=> (loopActive && stickyChange));

  a_r10_sticky_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stickyChange) |-> $past(stickyClr));

endmodule

// File: rtl/lbSearchTop.sv
module lbSearchTop
  import lbSearchPkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_BITS  = 8,
  parameter int ORDER      = 7,
  parameter int UP_TAP     = 6,
  parameter int DOWN_TAP   = 4,
  parameter int DETECT_LEN = 2048,
  parameter int ERR_LIMIT  = 8,
  parameter int TO_W       = 20,
  parameter int TO_DEFAULT = 65536
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 bitEn,
  input  logic                 frameSync,
  input  logic [NUM_SLOTS-1:0] slotEnable,
  input  logic [TO_W-1:0]      timeoutWin,
  input  logic                 hostRestart,
  input  logic                 stickyClr,
  input  logic                 irqEn,
  output logic                 loopActive,
  output logic                 timeoutFlag,
  output logic                 stickyChange,
  output logic                 irq
);
  lbStrobe_t str;
  lbEvent_t  evt;

  lbDatapath #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS), .ORDER(ORDER),
    .UP_TAP(UP_TAP), .DOWN_TAP(DOWN_TAP), .DETECT_LEN(DETECT_LEN),
    .ERR_LIMIT(ERR_LIMIT), .TO_W(TO_W), .TO_DEFAULT(TO_DEFAULT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .serIn(serIn), .bitEn(bitEn),
    .frameSync(frameSync), .slotEnable(slotEnable), .timeoutWin(timeoutWin),
    .evt(evt)
  );

  lbControl u_ctl (
    .clk(clk), .rstN(rstN), .hostRestart(hostRestart), .stickyClr(stickyClr),
    .irqEn(irqEn), .evt(evt), .str(str), .loopActive(loopActive),
    .timeoutFlag(timeoutFlag), .stickyChange(stickyChange), .irq(irq)
  );

endmodule

// File: tb/lbSearchTop_tb.sv
`timescale 1ns/1ps
module lbSearchTop_tb;
  localparam int K_UP = 0, K_DOWN = 1, K_ONES = 2, K_ZEROS = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0, bitEn = 1'b0, frameSync = 1'b0;
  logic [31:0] slotEnable = '1;
  logic [19:0] timeoutWin = 20'd60000;
  logic        hostRestart = 1'b0, stickyClr = 1'b0, irqEn = 1'b1;
  logic        loopActive, timeoutFlag, stickyChange, irq;

  int checks = 0, errs = 0;
  int pos = 0;
  logic [6:0] hist = 7'h5A;

  always #4 clk = ~clk;

  lbSearchTop u_dut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .bitEn(bitEn), .frameSync(frameSync),
    .slotEnable(slotEnable), .timeoutWin(timeoutWin), .hostRestart(hostRestart),
    .stickyClr(stickyClr), .irqEn(irqEn), .loopActive(loopActive),
    .timeoutFlag(timeoutFlag), .stickyChange(stickyChange), .irq(irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic genBit(int kind, output logic b);
    logic nb;
    case (kind)
      K_UP:    begin nb = hist[6] ^ hist[5]; hist = {hist[5:0], nb}; b = nb; end
      K_DOWN:  begin nb = hist[6] ^ hist[3]; hist = {hist[5:0], nb}; b = nb; end
      K_ONES:  b = 1'b1;
      default: b = 1'b0;
    endcase
  endtask

  // One bit cycle; called and returns at a falling edge
  task automatic drive(logic b, logic en);
    serIn = b; bitEn = en; frameSync = en && (pos == 0);
    @(posedge clk);
    if (en) pos = (pos + 1) % 256;
    @(negedge clk);
    bitEn = 1'b0; frameSync = 1'b0;
  endtask

  // Send n searched bits of a kind; disabled slots carry alternating noise
  task automatic sendEn(int n, int kind, int f1 = -1, int f2 = -1, int f3 = -1);
    int cnt = 0;
    logic b;
    while (cnt < n) begin
      if (slotEnable[pos / 8]) begin
        genBit(kind, b);
        if (cnt == f1 || cnt == f2 || cnt == f3) b = ~b;
        drive(b, 1'b1);
        cnt++;
      end else begin
        drive(pos[0], 1'b1);
      end
    end
  endtask

  task automatic restart();
    hostRestart = ~hostRestart;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clearSticky();
    stickyClr = 1'b1;
    @(posedge clk); @(negedge clk);
    stickyClr = 1'b0;
  endtask

  task automatic testReset();
    chk("R3", "loopActive after reset", loopActive, 0);
    chk("R8", "timeoutFlag after reset", timeoutFlag, 0);
    chk("R10", "sticky after reset", stickyChange, 0);
    chk("R10", "irq after reset", irq, 0);
  endtask

  task automatic testUpAndDown();
    slotEnable = '1; timeoutWin = 20'd60000;
    restart();
    sendEn(2054, K_UP);
    chk("R4", "loop before last bit", loopActive, 0);
    sendEn(1, K_UP);
    chk("R4", "loop at 2055th bit", loopActive, 1);
    chk("R10", "sticky on loop-up", stickyChange, 1);
    clearSticky();
    chk("R10", "sticky cleared", stickyChange, 0);
    sendEn(2048, K_UP);
    chk("R7", "loop-up ignored while looped", stickyChange, 0);
    sendEn(2047, K_DOWN);
    chk("R7", "loop before down window end", loopActive, 1);
    sendEn(1, K_DOWN);
    chk("R7", "loop cleared by loop-down", loopActive, 0);
    chk("R10", "sticky on loop-down", stickyChange, 1);
    clearSticky();
  endtask

  task automatic testDownIgnored();
    restart();
    sendEn(2055, K_DOWN);
    chk("R7", "loop-down ignored while idle", loopActive, 0);
    chk("R7", "no sticky from idle loop-down", stickyChange, 0);
  endtask

  task automatic testSparse();
    slotEnable = 32'h0000_F000;
    restart();
    sendEn(2054, K_UP);
    chk("R1", "sparse loop before last bit", loopActive, 0);
    sendEn(1, K_UP);
    chk("R2", "sparse loop at 2055th bit", loopActive, 1);
    clearSticky();
    restart();
    chk("R3", "restart clears loop", loopActive, 0);
    chk("R3", "restart leaves sticky clear", stickyChange, 0);
    slotEnable = '1;
  endtask

  task automatic testTolerance();
    restart();
    sendEn(2055, K_UP, 507, 1007);
    chk("R5", "two flips still detect", loopActive, 1);
    clearSticky();
    restart();
    sendEn(2055, K_UP, 507, 1007, 1507);
    chk("R5", "three flips reject", loopActive, 0);
  endtask

  task automatic testZeros();
    restart();
    sendEn(2055, K_ZEROS);
    chk("R6", "zeros first window", loopActive, 0);
    sendEn(2048, K_ZEROS);
    chk("R6", "zeros second window", loopActive, 0);
  endtask

  task automatic testTimeout();
    timeoutWin = 20'd1000;
    restart();
    sendEn(999, K_ONES);
    chk("R8", "no timeout at 999", timeoutFlag, 0);
    sendEn(1, K_ONES);
    chk("R8", "timeout at 1000", timeoutFlag, 1);
    chk("R10", "sticky on timeout", stickyChange, 1);
    chk("R10", "irq enabled", irq, 1);
    irqEn = 1'b0; #1;
    chk("R10", "irq masked", irq, 0);
    irqEn = 1'b1; @(negedge clk);
    clearSticky();
    chk("R10", "irq after clear", irq, 0);
    sendEn(500, K_ONES);
    chk("R8", "timeout holds", timeoutFlag, 1);
    chk("R10", "no sticky while steady", stickyChange, 0);
    restart();
    chk("R3", "restart clears timeout", timeoutFlag, 0);
  endtask

  task automatic testLoopBlocksTimeout();
    timeoutWin = 20'd3000;
    restart();
    sendEn(2055, K_UP);
    chk("R9", "loop active", loopActive, 1);
    sendEn(2000, K_ONES);
    chk("R9", "no timeout during loopback", timeoutFlag, 0);
    clearSticky();
  endtask

  task automatic testDefaultWindow();
    timeoutWin = '0;
    restart();
    sendEn(65535, K_ONES);
    chk("R8", "default window not yet", timeoutFlag, 0);
    sendEn(1, K_ONES);
    chk("R8", "default window 65536", timeoutFlag, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUpAndDown();
    testDownIgnored();
    testSparse();
    testTolerance();
    testZeros();
    testTimeout();
    testLoopBlocksTimeout();
    testDefaultWindow();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule